// File: doc/BRIEF.md
# UART Receive Queue with Level Interrupt

This block is the receive-side holding queue behind a UART register interface. The line side (a deserializer) offers one character per cycle together with its framing and parity error bits. The queue keeps each character as a 12-bit entry and hands entries to the bus side through a data-register read port. A line-break event stores a special break entry.

The queue has two depths. When FIFO mode is on it holds 16 entries; when FIFO mode is off it holds a single entry. Changing the mode bit at runtime empties the queue at once.

A receive interrupt request is raised when a push brings the fill count exactly to the trigger level, which is fixed at 1. It is dropped when a read leaves the count one below that level. A status register keeps the error bits of the most recently read entry. A readiness output tells the line side whether another character fits.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty (`rxEmpty`=1, `rxFull`=0), `canAccept`=1, `rxIrq`=0, `rxStatus`=0, `lvlReg`=0x12 and FIFO mode is off (depth 1).
- R2: With FIFO mode on, the queue holds 16 entries and returns them in arrival order. `rxFull` rises on the 16th push, and `popData` always shows the oldest entry.
- R3: With FIFO mode off, a single push fills the queue (`rxFull`=1, `canAccept`=0).
- R4: A push that arrives while the queue is full is discarded. The next entry that is stored carries the overrun flag in `popData` bit 11.
- R5: `rxIrq` rises on a push that makes the count equal 1. It falls on a read that leaves the count at 0, and no other push or read changes it.
- R6: A read while the queue is empty returns the entry at the current read position. The count stays at 0 and `rxEmpty` stays 1.
- R7: On each read, `rxStatus` takes bits 11:8 of the entry returned: bit 3 overrun, bit 2 break, bit 1 parity, bit 0 framing. A `statusClr` pulse zeroes it, and a read in the same cycle takes precedence over the clear.
- R8: Changing `fifoMode` empties the queue and resets the read position. A push or read in that same cycle is ignored, and `rxIrq` keeps its value.
- R9: `breakEvent` stores the entry 0x400 (character 0, break bit 10) unless `loopbackOn` is 1. It wins over a line push in the same cycle; that line character is lost without an overrun.
- R10: A push together with a read, while at least one entry is held and the queue is not full, leaves the count unchanged and keeps the order.
- R11: A write to the level register is stored and shown on `lvlReg`, but the trigger level stays 1.
- R12: `canAccept` is 1 exactly when the count is below the current depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | 1: 16-entry depth, 0: 1-entry depth; any change flushes |
| loopbackOn | input | 1 | Suppresses break entries when 1 |
| pushValid | input | 1 | Line-side character present this cycle |
| pushChar | input | 8 | Received character |
| pushFrm | input | 1 | Framing error of the character |
| pushPar | input | 1 | Parity error of the character |
| breakEvent | input | 1 | Line break detected |
| canAccept | output | 1 | Room for another entry |
| popReq | input | 1 | Data-register read strobe |
| popData | output | 12 | Entry at read position (combinational) |
| statusClr | input | 1 | Write to receive-status register |
| rxStatus | output | 4 | Error bits of last entry read |
| lvlWrite | input | 1 | Write to level register |
| lvlData | input | 6 | Level register write value |
| lvlReg | output | 6 | Level register contents |
| rxFull | output | 1 | Queue full |
| rxEmpty | output | 1 | Queue empty |
| rxIrq | output | 1 | Receive-level interrupt request |

## Verification
The bench aims at the exact-equality interrupt. It checks that a second push does not re-trigger it, that it stays set while entries remain, and that it survives a mode flush. A threshold-based design would drop it early, and a design that flushed the interrupt would lose it. It checks that a push into a full queue is dropped and that only the next stored entry is flagged; a design that overwrote the head or flagged the wrong entry would show a changed character or a missing bit 11. It also reads an empty queue at a known wrapped position, performs a simultaneous push and read, issues a break while a line character arrives, and clears the status in the same cycle as a read. A wrong slot computation, a lost count update or a reversed priority would each change a data or flag value that the bench compares.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  // Bit order is decoded by software: [11] ovr, [10] brk, [9] par, [8] frm
  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] ch;
  } rxEntry_t;

  localparam int ENTRY_W = $bits(rxEntry_t);
  localparam int STAT_W  = ENTRY_W - CHAR_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic capStat;
    logic clrStat;
  } rxStrobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rxStrobe_t             strb,
  input  logic [DEPTH_LOG2-1:0] wrSlot,
  input  logic [DEPTH_LOG2-1:0] rdSlot,
  input  rxEntry_t              wrData,
  output rxEntry_t              rdData,
  output logic [STAT_W-1:0]     status
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  rxEntry_t          mem [DEPTH];
  logic [DEPTH-1:0]  slotHit;
  logic [STAT_W-1:0] statQ;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign slotHit[g] = strb.wrEn && (wrSlot == DEPTH_LOG2'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slotHit[i]) mem[i] <= wrData;
      end
    end
  end

  assign rdData = mem[rdSlot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            statQ <= '0;
    else if (strb.capStat) statQ <= rdData[ENTRY_W-1:CHAR_W];
    else if (strb.clrStat) statQ <= '0;
  end

  assign status = statQ;
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int                 DEPTH_LOG2 = 4,
  parameter int                 TRIG_LEVEL = 1,
  parameter int                 LVL_W      = 6,
  parameter logic [LVL_W-1:0]   LVL_RST    = 6'h12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifoMode,
  input  logic                  loopbackOn,
  input  logic                  pushValid,
  input  logic [CHAR_W-1:0]     pushChar,
  input  logic                  pushFrm,
  input  logic                  pushPar,
  input  logic                  breakEvent,
  input  logic                  popReq,
  input  logic                  statusClr,
  input  logic                  lvlWrite,
  input  logic [LVL_W-1:0]      lvlData,
  output rxStrobe_t             strb,
  output logic [DEPTH_LOG2-1:0] wrSlot,
  output logic [DEPTH_LOG2-1:0] rdSlot,
  output rxEntry_t              wrData,
  output logic                  canAccept,
  output logic                  rxFull,
  output logic                  rxEmpty,
  output logic                  rxIrq,
  output logic [LVL_W-1:0]      lvlReg,
  output logic                  fifoOn
);
  localparam int               DEPTH  = 1 << DEPTH_LOG2;
  localparam int               CNT_W  = DEPTH_LOG2 + 1;
  localparam logic [CNT_W-1:0] TRIG_C = CNT_W'(TRIG_LEVEL);
  localparam logic [CNT_W-1:0] DEP_HI = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] DEP_LO = CNT_W'(1);

  logic                  modeQ, fullQ, emptyQ, irqQ, ovrQ;
  logic                  fullD, emptyD, irqD, ovrD;
  logic [CNT_W-1:0]      cntQ, cntD, depth;
  logic [DEPTH_LOG2-1:0] posQ, posD, mask;
  logic [LVL_W-1:0]      lvlQ;
  logic                  toggle, brkGo, pushGo, isFull;
  logic                  accept, drop, popGo, popTake;

  always_comb begin
    depth   = modeQ ? DEP_HI : DEP_LO;
    mask    = modeQ ? '1 : '0;
    toggle  = fifoMode != modeQ;
    brkGo   = breakEvent && !loopbackOn;
    pushGo  = brkGo || pushValid;
    isFull  = cntQ == depth;
    accept  = pushGo && !isFull && !toggle;
    drop    = pushGo && isFull && !toggle;
    popGo   = popReq && !toggle;
    popTake = popGo && (cntQ != '0);
  end

  always_comb begin
    wrData.ovr = ovrQ;
    wrData.brk = brkGo;
    wrData.par = brkGo ? 1'b0 : pushPar;
    wrData.frm = brkGo ? 1'b0 : pushFrm;
    wrData.ch  = brkGo ? '0 : pushChar;
  end

  always_comb begin
    cntD = cntQ;
    posD = posQ;
    if (toggle) begin
      cntD = '0;
      posD = '0;
    end else begin
      if (accept)  cntD = cntD + CNT_W'(1);
      if (popTake) begin
        cntD = cntD - CNT_W'(1);
        posD = (posQ + DEPTH_LOG2'(1)) & mask;
      end
    end
  end

  always_comb begin
    irqD = irqQ;
    if (accept && !popTake && cntD == TRIG_C)
      irqD = 1'b1;
    else if (popGo && !accept && (cntD + CNT_W'(1)) == TRIG_C)
      irqD = 1'b0;

    ovrD = ovrQ;
    if (toggle)      ovrD = 1'b0;
    else if (drop)   ovrD = 1'b1;
    else if (accept) ovrD = 1'b0;

    fullD  = cntD == (fifoMode ? DEP_HI : DEP_LO);
    emptyD = cntD == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ  <= 1'b0;
      cntQ   <= '0;
      posQ   <= '0;
      fullQ  <= 1'b0;
      emptyQ <= 1'b1;
      irqQ   <= 1'b0;
      ovrQ   <= 1'b0;
      lvlQ   <= LVL_RST;
    end else begin
      modeQ  <= fifoMode;
      cntQ   <= cntD;
      posQ   <= posD;
      fullQ  <= fullD;
      emptyQ <= emptyD;
      irqQ   <= irqD;
      ovrQ   <= ovrD;
      if (lvlWrite) lvlQ <= lvlData;
    end
  end

  assign strb.wrEn    = accept;
  assign strb.capStat = popGo;
  assign strb.clrStat = statusClr;
  assign wrSlot       = (posQ + cntQ[DEPTH_LOG2-1:0]) & mask;
  assign rdSlot       = posQ;
  assign canAccept    = cntQ < depth;
  assign rxFull       = fullQ;
  assign rxEmpty      = emptyQ;
  assign rxIrq        = irqQ;
  assign lvlReg       = lvlQ;
  assign fifoOn       = modeQ;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int               DEPTH_LOG2 = 4,
  parameter int               TRIG_LEVEL = 1,
  parameter int               LVL_W      = 6,
  parameter logic [LVL_W-1:0] LVL_RST    = 6'h12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifoMode,
  input  logic               loopbackOn,
  input  logic               pushValid,
  input  logic [CHAR_W-1:0]  pushChar,
  input  logic               pushFrm,
  input  logic               pushPar,
  input  logic               breakEvent,
  output logic               canAccept,
  input  logic               popReq,
  output logic [ENTRY_W-1:0] popData,
  input  logic               statusClr,
  output logic [STAT_W-1:0]  rxStatus,
  input  logic               lvlWrite,
  input  logic [LVL_W-1:0]   lvlData,
  output logic [LVL_W-1:0]   lvlReg,
  output logic               rxFull,
  output logic               rxEmpty,
  output logic               rxIrq
);
  rxStrobe_t             strb;
  logic [DEPTH_LOG2-1:0] wrSlot, rdSlot;
  rxEntry_t              wrData, rdData;
  logic                  fifoOn;

  rxq_ctrl #(
    .DEPTH_LOG2(DEPTH_LOG2), .TRIG_LEVEL(TRIG_LEVEL),
    .LVL_W(LVL_W), .LVL_RST(LVL_RST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifoMode(fifoMode), .loopbackOn(loopbackOn),
    .pushValid(pushValid), .pushChar(pushChar), .pushFrm(pushFrm),
    .pushPar(pushPar), .breakEvent(breakEvent), .popReq(popReq),
    .statusClr(statusClr), .lvlWrite(lvlWrite), .lvlData(lvlData),
    .strb(strb), .wrSlot(wrSlot), .rdSlot(rdSlot), .wrData(wrData),
    .canAccept(canAccept), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxIrq(rxIrq), .lvlReg(lvlReg), .fifoOn(fifoOn)
  );

  rxq_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrSlot(wrSlot),
    .rdSlot(rdSlot), .wrData(wrData), .rdData(rdData), .status(rxStatus)
  );

  assign popData = rdData;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk
  import rxq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifoMode,
  input logic               pushValid,
  input logic               breakEvent,
  input logic               canAccept,
  input logic               popReq,
  input logic [ENTRY_W-1:0] popData,
  input logic [STAT_W-1:0]  rxStatus,
  input logic               lvlWrite,
  input logic [LVL_W-1:0]   lvlData,
  input logic [LVL_W-1:0]   lvlReg,
  input logic               rxFull,
  input logic               rxEmpty,
  input logic               rxIrq,
  input logic               fifoOn
);
  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxFull && rxEmpty));

  // R12
  ready_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    canAccept != rxFull);

  // R8
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoMode != fifoOn) |=> (rxEmpty && !rxFull));

  // R5
  irq_rise_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxIrq) |-> $past(pushValid || breakEvent));

  // R7
  status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && fifoMode == fifoOn) |=> rxStatus == $past(popData[ENTRY_W-1:CHAR_W]));

  // R11
  level_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvlWrite |=> lvlReg == $past(lvlData));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxFull && !popReq && fifoMode == fifoOn) |=> rxFull);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_rx_queue_tb_top.sv
module uart_rx_queue_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifoMode = 0, loopbackOn = 0, pushValid = 0, pushFrm = 0, pushPar = 0;
  logic breakEvent = 0, popReq = 0, statusClr = 0, lvlWrite = 0;
  logic [7:0]  pushChar = '0;
  logic [5:0]  lvlData = '0;
  logic        canAccept, rxFull, rxEmpty, rxIrq;
  logic [11:0] popData;
  logic [3:0]  rxStatus;
  logic [5:0]  lvlReg;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pushValid = 0; popReq = 0; breakEvent = 0; statusClr = 0; lvlWrite = 0;
    pushFrm = 0; pushPar = 0;
  endtask

  task automatic push(logic [7:0] c, logic f = 0, logic p = 0);
    pushValid = 1; pushChar = c; pushFrm = f; pushPar = p;
    step();
  endtask

  task automatic pop();
    popReq = 1;
    step();
  endtask

  task automatic setMode(logic m);
    fifoMode = m;
    step();
  endtask

  task automatic t_reset();
    check("R1 empty", rxEmpty, 1);
    check("R1 full", rxFull, 0);
    check("R1 ready", canAccept, 1);
    check("R1 irq", rxIrq, 0);
    check("R1 status", rxStatus, 0);
    check("R1 level", lvlReg, 6'h12);
  endtask

  task automatic t_single();
    push(8'h41, 1);
    check("R3 full", rxFull, 1);
    check("R12 ready", canAccept, 0);
    check("R5 irq set", rxIrq, 1);
    push(8'h42);
    check("R4 head kept", popData, 12'h141);
    pop();
    check("R7 status frm", rxStatus, 4'b0001);
    check("R5 irq clear", rxIrq, 0);
    check("R3 empty", rxEmpty, 1);
    push(8'h43);
    check("R4 overrun flag", popData, 12'h843);
    pop();
    check("R4 status ovr", rxStatus, 4'b1000);
    statusClr = 1; step();
    check("R7 clear", rxStatus, 0);
  endtask

  task automatic t_fifo();
    setMode(1);
    for (int i = 0; i < 16; i++) begin
      push(8'h10 + 8'(i));
      if (i == 0)  check("R5 irq first", rxIrq, 1);
      if (i == 14) check("R12 ready 15", canAccept, 1);
      if (i == 14) check("R2 not full 15", rxFull, 0);
    end
    check("R2 full 16", rxFull, 1);
    check("R12 ready 16", canAccept, 0);
    for (int i = 0; i < 16; i++) begin
      check("R2 order", popData, 12'h010 + 12'(i));
      pop();
      if (i == 14) check("R5 irq held", rxIrq, 1);
    end
    check("R5 irq drop", rxIrq, 0);
    check("R2 empty", rxEmpty, 1);
  endtask

  task automatic t_simul();
    push(8'h60); push(8'h61); push(8'h62);
    pushValid = 1; pushChar = 8'h63;
    check("R10 head", popData, 12'h060);
    popReq = 1; step();
    check("R10 irq", rxIrq, 1);
    for (int i = 1; i < 4; i++) begin
      check("R10 order", popData, 12'h060 + 12'(i));
      check("R10 not empty", rxEmpty, 0);
      pop();
    end
    check("R10 empty", rxEmpty, 1);
  endtask

  task automatic t_emptyPop();
    check("R6 stale entry", popData, 12'h014);
    pop();
    check("R6 still empty", rxEmpty, 1);
    check("R6 not full", rxFull, 0);
    check("R6 ready", canAccept, 1);
    check("R6 same entry", popData, 12'h014);
  endtask

  task automatic t_toggle();
    push(8'h70, 0, 1); push(8'h71);
    pushValid = 1; pushChar = 8'h72; popReq = 1; fifoMode = 0; step();
    check("R8 empty", rxEmpty, 1);
    check("R8 full", rxFull, 0);
    check("R8 irq kept", rxIrq, 1);
    check("R8 status kept", rxStatus, 0);
    push(8'h73);
    check("R8 slot0", popData, 12'h073);
    pop();
    check("R8 irq clear", rxIrq, 0);
  endtask

  task automatic t_break();
    loopbackOn = 1; breakEvent = 1; step();
    check("R9 loopback", rxEmpty, 1);
    loopbackOn = 0; breakEvent = 1; pushValid = 1; pushChar = 8'h5a; step();
    check("R9 break entry", popData, 12'h400);
    check("R9 full", rxFull, 1);
    pop();
    check("R9 status brk", rxStatus, 4'b0100);
    push(8'h59);
    check("R9 no overrun", popData, 12'h059);
    pop();
  endtask

  task automatic t_status();
    push(8'h33, 0, 1);
    popReq = 1; statusClr = 1; step();
    check("R7 capture wins", rxStatus, 4'b0010);
    statusClr = 1; step();
    check("R7 cleared", rxStatus, 0);
  endtask

  task automatic t_level();
    lvlWrite = 1; lvlData = 6'h05; step();
    check("R11 stored", lvlReg, 6'h05);
    setMode(1);
    push(8'h01);
    check("R11 trig 1", rxIrq, 1);
    push(8'h02);
    pop();
    check("R11 irq held", rxIrq, 1);
    pop();
    check("R11 irq low", rxIrq, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_single();
    t_fifo();
    t_simul();
    t_emptyPop();
    t_toggle();
    t_break();
    t_status();
    t_level();
    finishRun();
  end
endmodule